// File: doc/BRIEF.md
# System Control Coprocessor Register Block

This block is the register side of a system-control coprocessor for a small processor core. The pipeline issues register commands, each carrying a register number, a CRm field and an opcode2 field. Write commands update the stored registers. Read data is returned combinationally for the register number presented on the command port.

The block stores six registers: the control word, the page-table base, the domain permissions, fault status, fault address and the process ID. In the control word, every bit the architecture fixes reads back its fixed value, whatever software writes there. Writes to register 7 are cache maintenance commands and writes to register 8 are TLB maintenance commands. Each one is decoded into a single one-hot request towards the memory system. That request stays high until the matching done input pulses. While it is pending, the command port is not ready.

A memory abort loads the fault address and the fault status on the clock edge at which it is signalled.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the block reads as follows. Register 0 returns the ID parameter. Register 1 reads 0x0000_4878. Registers 2, 3, 5, 6 and 13 read zero. `cmd_ready` is high and no request bit is set.
- R2: In register 1, only bits 0, 2, 8, 9 and 12 store written data. Bits 1, 7, 13 and 15 always read 0, bits 3, 4, 5, 6, 11 and 14 always read 1, and every other bit reads 0. Writing all ones reads back 0x0000_5B7D, and writing zero reads back 0x0000_4878.
- R3: Register 2 (page-table base in bits 31:14, with the low bits kept as written) and register 3 (domain X in bits 2X+1:2X) both store and return all 32 written bits.
- R4: A register 7 write with opcode2 = 0 sets exactly one bit of `cache_req`. The CRm mapping is: 0111 sets bit 0 (flush all), 0101 sets bit 1 (flush I), 0110 sets bit 2 (flush D), 1011 sets bit 3 (clean all), 1010 sets bit 4 (clean D), 1111 sets bit 5 (clean+flush all), and 1110 sets bit 6 (clean+flush D).
- R5: A register 7 write with any other CRm value, or with any nonzero opcode2, sets bit 5 of `cache_req` (clean and flush all).
- R6: A register 8 write with opcode2 = 0 sets one bit of `tlb_req`. CRm 0101 sets bit 1 (flush I TLB), CRm 0110 sets bit 2 (flush D TLB), and every other combination sets bit 0 (flush all).
- R7: A request stays set until its done input is high at a clock edge, and it clears on that edge. While any request is set, `cmd_ready` is low and write commands have no effect.
- R8: An abort loads register 6 with `abort_addr` and loads register 5 with {domain, status} in bits 7:4 and 3:0 on the same clock edge. Register 5 bits 31:8 always read 0, and software writes to it keep only bits 7:0.
- R9: Register 13 keeps only bits 31:25 (process ID); all other bits read 0.
- R10: Reads of registers 4, 7, 8, 9 to 12, 14 and 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_reg | input | 4 | Register number |
| cmd_crm | input | 4 | CRm field |
| cmd_op2 | input | 3 | Opcode2 field |
| cmd_wdata | input | 32 | Write data |
| cmd_ready | output | 1 | Command port can accept a write |
| rd_data | output | 32 | Read value of register `cmd_reg` |
| ctrl_word | output | 32 | Current control word for the memory system |
| abort_valid | input | 1 | Abort report strobe |
| abort_addr | input | 32 | Faulting address |
| abort_status | input | 4 | Fault status code |
| abort_domain | input | 4 | Fault domain |
| cache_req | output | 7 | One-hot cache maintenance request |
| cache_done | input | 1 | Cache operation finished |
| tlb_req | output | 3 | One-hot TLB maintenance request |
| tlb_done | input | 1 | TLB operation finished |

## Verification
The assertions assume that `cache_done` and `tlb_done` are raised only while the matching request is pending, and only for a single cycle. They also assume that an abort is never reported in the same cycle as a software write to the fault registers. The stimulus raises a done pulse only after it has seen the request at the ports, holds it for exactly one cycle, and keeps every abort apart from command traffic. It also issues writes during a pending request to confirm they are dropped. Within the same cycle, it changes inputs only at the falling clock edge.

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter logic [31:0] ID_VALUE = 32'h4105_7A00,
  parameter int CACHE_OPS = 7,
  parameter int TLB_OPS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic [3:0]           cmd_reg,
  input  logic [3:0]           cmd_crm,
  input  logic [2:0]           cmd_op2,
  input  logic [31:0]          cmd_wdata,
  output logic                 cmd_ready,
  output logic [31:0]          rd_data,
  output logic [31:0]          ctrl_word,
  input  logic                 abort_valid,
  input  logic [31:0]          abort_addr,
  input  logic [3:0]           abort_status,
  input  logic [3:0]           abort_domain,
  output logic [CACHE_OPS-1:0] cache_req,
  input  logic                 cache_done,
  output logic [TLB_OPS-1:0]   tlb_req,
  input  logic                 tlb_done
);
  localparam logic [31:0] CTRL_WMASK = 32'h0000_1305;
  localparam logic [31:0] CTRL_FIXED = 32'h0000_4878;

  logic [31:0] ctrl_q, ttb_q, dac_q, far_q;
  logic [7:0]  fsr_q;
  logic [6:0]  pid_q;
  logic [CACHE_OPS-1:0] cache_sel;
  logic [TLB_OPS-1:0]   tlb_sel;
  logic wr;

  assign cmd_ready = ~|cache_req & ~|tlb_req;
  assign wr        = cmd_valid & cmd_write & cmd_ready;
  assign ctrl_word = (ctrl_q & CTRL_WMASK) | CTRL_FIXED;

  always_comb begin
    cache_sel = '0;
    cache_sel[5] = 1'b1;
    if (cmd_op2 == 3'd0) begin
      case (cmd_crm)
        4'b0111: cache_sel = CACHE_OPS'(1 << 0);
        4'b0101: cache_sel = CACHE_OPS'(1 << 1);
        4'b0110: cache_sel = CACHE_OPS'(1 << 2);
        4'b1011: cache_sel = CACHE_OPS'(1 << 3);
        4'b1010: cache_sel = CACHE_OPS'(1 << 4);
        4'b1111: cache_sel = CACHE_OPS'(1 << 5);
        4'b1110: cache_sel = CACHE_OPS'(1 << 6);
        default: ;
      endcase
    end
  end

  always_comb begin
    tlb_sel = TLB_OPS'(1);
    if (cmd_op2 == 3'd0) begin
      case (cmd_crm)
        4'b0101: tlb_sel = TLB_OPS'(1 << 1);
        4'b0110: tlb_sel = TLB_OPS'(1 << 2);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ttb_q  <= '0;
      dac_q  <= '0;
      far_q  <= '0;
      fsr_q  <= '0;
      pid_q  <= '0;
    end else begin
      if (wr) begin
        case (cmd_reg)
          4'd1:  ctrl_q <= cmd_wdata & CTRL_WMASK;
          4'd2:  ttb_q  <= cmd_wdata;
          4'd3:  dac_q  <= cmd_wdata;
          4'd5:  fsr_q  <= cmd_wdata[7:0];
          4'd6:  far_q  <= cmd_wdata;
          4'd13: pid_q  <= cmd_wdata[31:25];
          default: ;
        endcase
      end
      if (abort_valid) begin
        far_q <= abort_addr;
        fsr_q <= {abort_domain, abort_status};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_req <= '0;
      tlb_req   <= '0;
    end else begin
      if (cache_done) cache_req <= '0;
      else if (wr && cmd_reg == 4'd7) cache_req <= cache_sel;
      if (tlb_done) tlb_req <= '0;
      else if (wr && cmd_reg == 4'd8) tlb_req <= tlb_sel;
    end
  end

  always_comb begin
    case (cmd_reg)
      4'd0:    rd_data = ID_VALUE;
      4'd1:    rd_data = ctrl_word;
      4'd2:    rd_data = ttb_q;
      4'd3:    rd_data = dac_q;
      4'd5:    rd_data = {24'd0, fsr_q};
      4'd6:    rd_data = far_q;
      4'd13:   rd_data = {pid_q, 25'd0};
      default: rd_data = '0;
    endcase
  end

  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_ready && cmd_reg == 4'd1) |=>
      (ctrl_word[12] == $past(cmd_wdata[12]) && ctrl_word[0] == $past(cmd_wdata[0])));

  // R4
  flush_all_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_ready && cmd_reg == 4'd7 &&
     cmd_op2 == 3'd0 && cmd_crm == 4'b0111) |=> (cache_req == CACHE_OPS'(1)));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cache_req && !cache_done) |=> $stable(cache_req));

  // R7
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tlb_req && tlb_done) |=> (tlb_req == '0));

  // R7
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cache_req) && $onehot0(tlb_req));

  // R8
  abort_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |=> (far_q == $past(abort_addr) &&
                     fsr_q == {$past(abort_domain), $past(abort_status)}));

  // R9
  pid_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_ready && cmd_reg == 4'd13) |=>
      (pid_q == $past(cmd_wdata[31:25])));
endmodule

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb_top;
  localparam logic [31:0] ID = 32'h4105_7A00;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0;
  logic [3:0] cmd_reg = 0, cmd_crm = 0;
  logic [2:0] cmd_op2 = 0;
  logic [31:0] cmd_wdata = 0, rd_data, ctrl_word, abort_addr = 0;
  logic cmd_ready, abort_valid = 0, cache_done = 0, tlb_done = 0;
  logic [3:0] abort_status = 0, abort_domain = 0;
  logic [6:0] cache_req;
  logic [2:0] tlb_req;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sysctl_regfile #(.ID_VALUE(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_reg(cmd_reg), .cmd_crm(cmd_crm), .cmd_op2(cmd_op2), .cmd_wdata(cmd_wdata),
    .cmd_ready(cmd_ready), .rd_data(rd_data), .ctrl_word(ctrl_word),
    .abort_valid(abort_valid), .abort_addr(abort_addr), .abort_status(abort_status),
    .abort_domain(abort_domain), .cache_req(cache_req), .cache_done(cache_done),
    .tlb_req(tlb_req), .tlb_done(tlb_done));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] r, logic [3:0] crm, logic [2:0] op2, logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_reg = r; cmd_crm = crm; cmd_op2 = op2; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0;
  endtask

  task automatic rd_chk(string req, logic [3:0] r, logic [31:0] exp);
    cmd_reg = r; #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1", 0, ID);
    rd_chk("R1", 1, 32'h4878);
    rd_chk("R1", 2, 0); rd_chk("R1", 3, 0); rd_chk("R1", 5, 0);
    rd_chk("R1", 6, 0); rd_chk("R1", 13, 0);
    check("R1", {cmd_ready, cache_req, tlb_req}, 32'h400);
  endtask

  task automatic t_ctrl;
    wr(1, 0, 0, 32'hFFFF_FFFF); rd_chk("R2", 1, 32'h5B7D);
    check("R2", ctrl_word, 32'h5B7D);
    wr(1, 0, 0, 32'h0); rd_chk("R2", 1, 32'h4878);
    wr(1, 0, 0, 32'h0000_0104); rd_chk("R2", 1, 32'h497C);
  endtask

  task automatic t_base_dom;
    wr(2, 0, 0, 32'hABCD_5A3C); rd_chk("R3", 2, 32'hABCD_5A3C);
    wr(3, 0, 0, 32'h1B2D_E4C7); rd_chk("R3", 3, 32'h1B2D_E4C7);
  endtask

  task automatic maint(string req, bit tlb, logic [3:0] crm, logic [2:0] op2, logic [6:0] exp);
    wr(tlb ? 4'd8 : 4'd7, crm, op2, 0);
    if (tlb) check(req, {29'd0, tlb_req}, {25'd0, exp});
    else     check(req, {25'd0, cache_req}, {25'd0, exp});
    check("R7", {31'd0, cmd_ready}, 0);
    @(negedge clk);
    if (tlb) tlb_done = 1; else cache_done = 1;
    @(negedge clk);
    tlb_done = 0; cache_done = 0;
    check("R7", {cmd_ready, cache_req, tlb_req}, 32'h400);
  endtask

  task automatic t_cache;
    maint("R4", 0, 4'b0111, 0, 7'h01);
    maint("R4", 0, 4'b0101, 0, 7'h02);
    maint("R4", 0, 4'b0110, 0, 7'h04);
    maint("R4", 0, 4'b1011, 0, 7'h08);
    maint("R4", 0, 4'b1010, 0, 7'h10);
    maint("R4", 0, 4'b1111, 0, 7'h20);
    maint("R4", 0, 4'b1110, 0, 7'h40);
    maint("R5", 0, 4'b0001, 0, 7'h20);
    maint("R5", 0, 4'b0111, 3'd2, 7'h20);
  endtask

  task automatic t_tlb;
    maint("R6", 1, 4'b0111, 0, 7'h1);
    maint("R6", 1, 4'b0101, 0, 7'h2);
    maint("R6", 1, 4'b0110, 0, 7'h4);
    maint("R6", 1, 4'b0011, 0, 7'h1);
    maint("R6", 1, 4'b0101, 3'd1, 7'h1);
  endtask

  task automatic t_busy;
    wr(7, 4'b0101, 0, 0);
    repeat (3) @(negedge clk);
    check("R7", {25'd0, cache_req}, 32'h02);
    wr(2, 0, 0, 32'h1111_1111);
    wr(8, 4'b0110, 0, 0);
    rd_chk("R7", 2, 32'hABCD_5A3C);
    check("R7", {29'd0, tlb_req}, 0);
    @(negedge clk); cache_done = 1;
    @(negedge clk); cache_done = 0;
    check("R7", {31'd0, cmd_ready}, 1);
  endtask

  task automatic t_abort;
    wr(5, 0, 0, 32'hFFFF_FFAB); rd_chk("R8", 5, 32'hAB);
    @(negedge clk);
    abort_valid = 1; abort_addr = 32'hDEAD_BEEF; abort_status = 4'h5; abort_domain = 4'h9;
    @(negedge clk);
    abort_valid = 0;
    rd_chk("R8", 6, 32'hDEAD_BEEF);
    rd_chk("R8", 5, 32'h95);
  endtask

  task automatic t_pid_unimpl;
    wr(13, 0, 0, 32'hFFFF_FFFF); rd_chk("R9", 13, 32'hFE00_0000);
    wr(4, 0, 0, 32'hFFFF_FFFF);
    rd_chk("R10", 4, 0); rd_chk("R10", 9, 0); rd_chk("R10", 12, 0);
    rd_chk("R10", 15, 0); rd_chk("R10", 7, 0); rd_chk("R10", 8, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ctrl;
    t_base_dom;
    t_cache;
    t_tlb;
    t_busy;
    t_abort;
    t_pid_unimpl;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end
endmodule